// File: doc/BRIEF.md
# SDRAM Initialisation and Refresh Sequencer

This block owns the SDRAM command bus from reset until the memory is usable, and afterwards keeps the array refreshed. Following reset it waits out a clock-stabilisation count and the power-up pause. It then drives the fixed start-up order: one precharge of all banks, eight auto-refresh commands, and the mode-register write. Each step is spaced by the precharge time or the row cycle time, counted in clocks. When the mode-register write has settled, `ready` goes high.

From then on an interval timer marks when a refresh is owed. The refresh period comes from the row count of the devices: devices with 8k rows are refreshed twice as often as devices with 4k rows. The command bus normally belongs to the access scheduler, so the block raises `busReq` and sends the refresh only in a cycle where `busGnt` is high. Refreshes that fall due while the bus is withheld are remembered, up to a fixed limit.

A level request puts the memory into self-refresh and holds it there. Dropping the request raises clock enable, and the block then stays silent long enough for the device to finish leaving self-refresh.

Top module: `dram_maint_seq`

## Requirements
- R1: During reset, `cmd` is NOP (0), `cke` is 1, `ready` and `busReq` are 0. After reset release, only NOP appears until cycle STAB_CYCLES+PWRUP_CYCLES, counting the first cycle after release as cycle 0. In that cycle the first command appears: precharge-all (code 1), with `addr` bit AP_BIT set.
- R2: The start-up order is exactly one precharge-all, then exactly INIT_REFRESHES (8) auto-refresh commands (code 2), then one mode-register write (code 3) whose `addr` equals `modeWord`. No other command occurs during start-up.
- R3: The first start-up refresh comes exactly TRP_CYCLES after the precharge. Successive start-up refreshes are exactly TRC_CYCLES apart, and the mode-register write comes exactly TRC_CYCLES after the last refresh. Any command that follows a refresh waits at least TRC_CYCLES.
- R4: `ready` rises exactly MRD_CYCLES after the mode-register write, and only NOP is driven in between.
- R5: While the bus is granted, periodic refreshes are exactly REF_PERIOD_4K cycles apart when `bigRows`=0, and REF_PERIOD_4K/2 apart when `bigRows`=1. The first one comes exactly one period after `ready` rises.
- R6: A refresh after start-up is driven only in a cycle with `busGnt`=1. `busReq` stays high while a refresh is owed.
- R7: Refreshes owed while the bus is withheld are counted up to PEND_MAX, and further ones are dropped. Once the bus is granted, exactly the counted number are sent, TRC_CYCLES apart.
- R8: With `selfRefReq`=1 and `busGnt`=1 in the ready state, a refresh command is driven with `cke`=0 in that same cycle. Until the request drops, `cke` stays 0, `cmd` stays NOP and `ready` stays 0. A request without a grant does nothing except raise `busReq`. Entry clears the owed refreshes and restarts the interval, so the first refresh after leaving self-refresh comes exactly one period after `ready` returns.
- R9: `cke` rises in the cycle after `selfRefReq` falls. `ready` returns exactly TRC_CYCLES+1 cycles after `cke` rises, with only NOP in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bigRows | input | 1 | 1 = devices with 8k rows (half refresh period) |
| selfRefReq | input | 1 | Level request to enter and hold self-refresh |
| busGnt | input | 1 | The access scheduler lends the command bus |
| modeWord | input | ADDR_W | Value driven on `addr` with the mode-register write |
| cmd | output | 3 | Command: 0 NOP, 1 precharge-all, 2 refresh, 3 mode-register write |
| addr | output | ADDR_W | Address bus for the current command |
| cke | output | 1 | Clock enable to the devices |
| ready | output | 1 | Start-up finished and memory not in self-refresh |
| busReq | output | 1 | Block needs the command bus |

## Verification
Several properties are checked in every cycle: the minimum gaps after a precharge, a refresh or a mode-register write; that a refresh after start-up happens only under a grant; that no command is driven while clock enable is low; that the owed-refresh count stays within its limit and is empty after self-refresh entry; and that the mode-register write comes only after the full refresh count. Other behaviours appear only in the bench scenarios. These are the exact power-up wait, the command order and its exact spacing, the refresh period for each row setting, and saturation when the bus is withheld. They also include the exact delay from clock enable rising to `ready`, and the restart of the interval after self-refresh.

// File: rtl/dram_maint_pkg.sv
package dram_maint_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PREA = 3'd1,
    CMD_REF  = 3'd2,
    CMD_MRS  = 3'd3
  } cmd_e;

  typedef enum logic [2:0] {
    WK_PWRUP = 3'd0,
    WK_TRP   = 3'd1,
    WK_TRC   = 3'd2,
    WK_MRD   = 3'd3,
    WK_XSR   = 3'd4
  } waitKind_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic      loadWait;
    waitKind_e waitKind;
    logic      initRefInc;
    logic      refDone;
    logic      srefEnter;
    logic      tickEn;
  } ctlStrobe_t;

endpackage

// File: rtl/dram_maint_dp.sv
module dram_maint_dp
  import dram_maint_pkg::*;
#(
  parameter int STAB_CYCLES    = 8,
  parameter int PWRUP_CYCLES   = 5000,
  parameter int TRP_CYCLES     = 3,
  parameter int TRC_CYCLES     = 4,
  parameter int MRD_CYCLES     = 2,
  parameter int INIT_REFRESHES = 8,
  parameter int REF_PERIOD_4K  = 780,
  parameter int PEND_MAX       = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  logic       bigRows,
  output logic       waitDone,
  output logic       initRefDone,
  output logic       pendingNz
);

  localparam int REF_PERIOD_8K = REF_PERIOD_4K / 2;
  localparam int MAX_A   = (PWRUP_CYCLES > STAB_CYCLES) ? PWRUP_CYCLES : STAB_CYCLES;
  localparam int CNT_MAX = (MAX_A > TRC_CYCLES + 2) ? MAX_A : TRC_CYCLES + 2;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int TMR_W   = $clog2(REF_PERIOD_4K + 1);
  localparam int PEND_W  = $clog2(PEND_MAX + 1);
  localparam int INIT_W  = $clog2(INIT_REFRESHES + 1);

  // ---------------- wait counter ----------------
  logic [CNT_W-1:0] waitCnt;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    unique case (strobe.waitKind)
      WK_PWRUP: loadVal = CNT_W'(PWRUP_CYCLES - 1);
      WK_TRP:   loadVal = CNT_W'(TRP_CYCLES - 2);
      WK_TRC:   loadVal = CNT_W'(TRC_CYCLES - 2);
      WK_MRD:   loadVal = CNT_W'(MRD_CYCLES - 2);
      WK_XSR:   loadVal = CNT_W'(TRC_CYCLES);
      default:  loadVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                waitCnt <= CNT_W'(STAB_CYCLES - 1);
    else if (strobe.loadWait) waitCnt <= loadVal;
    else if (waitCnt != '0)   waitCnt <= waitCnt - 1'b1;
  end

  assign waitDone = (waitCnt == '0);

  // ---------------- start-up refresh count ----------------
  logic [INIT_W-1:0] initCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  initCnt <= '0;
    else if (strobe.initRefInc) initCnt <= initCnt + 1'b1;
  end

  assign initRefDone = (initCnt == INIT_W'(INIT_REFRESHES));

  // ---------------- refresh interval timer ----------------
  logic [TMR_W-1:0] timer;
  logic [TMR_W-1:0] periodM1;
  logic             tick;

  assign periodM1 = bigRows ? TMR_W'(REF_PERIOD_8K - 1) : TMR_W'(REF_PERIOD_4K - 1);
  assign tick     = strobe.tickEn && (timer >= periodM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 timer <= '0;
    else if (strobe.srefEnter) timer <= '0;
    else if (strobe.tickEn)    timer <= tick ? '0 : timer + 1'b1;
  end

  // ---------------- owed refreshes ----------------
  logic [PEND_W-1:0] pendCnt;

  generate
    if (PEND_MAX == 1) begin : g_pendFlag
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 pendCnt <= '0;
        else if (strobe.srefEnter) pendCnt <= '0;
        else if (tick)             pendCnt <= PEND_W'(1);
        else if (strobe.refDone)   pendCnt <= '0;
      end
    end else begin : g_pendCount
      logic up;
      assign up = tick && (pendCnt != PEND_W'(PEND_MAX));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 pendCnt <= '0;
        else if (strobe.srefEnter) pendCnt <= '0;
        else if (up && !strobe.refDone) pendCnt <= pendCnt + 1'b1;
        else if (!up && strobe.refDone && pendCnt != '0) pendCnt <= pendCnt - 1'b1;
      end
    end
  endgenerate

  assign pendingNz = (pendCnt != '0);

  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt <= PEND_W'(PEND_MAX));                                   // R7
  AST_SREF_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.srefEnter |=> !pendingNz);                                // R8

endmodule

// File: rtl/dram_maint_ctl.sv
module dram_maint_ctl
  import dram_maint_pkg::*;
#(
  parameter int TRP_CYCLES = 3,
  parameter int TRC_CYCLES = 4,
  parameter int MRD_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       waitDone,
  input  logic       initRefDone,
  input  logic       pendingNz,
  input  logic       busGnt,
  input  logic       selfRefReq,
  output ctlStrobe_t strobe,
  output cmd_e       cmdOut,
  output logic       ckeOut,
  output logic       readyOut,
  output logic       busReqOut
);

  typedef enum logic [3:0] {
    S_STAB, S_PWR, S_PREA, S_PWAIT, S_IREF, S_IWAIT, S_MRS, S_MWAIT,
    S_IDLE, S_RWAIT, S_SREF, S_XWAIT
  } state_e;

  state_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_STAB;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt  = state;
    strobe    = '0;
    cmdOut    = CMD_NOP;
    ckeOut    = 1'b1;
    readyOut  = 1'b0;
    busReqOut = 1'b0;
    unique case (state)
      S_STAB: if (waitDone) begin
        strobe.loadWait = 1'b1;
        strobe.waitKind = WK_PWRUP;
        stateNxt        = S_PWR;
      end
      S_PWR: if (waitDone) stateNxt = S_PREA;
      S_PREA: begin
        cmdOut          = CMD_PREA;
        strobe.loadWait = 1'b1;
        strobe.waitKind = WK_TRP;
        stateNxt        = S_PWAIT;
      end
      S_PWAIT: if (waitDone) stateNxt = S_IREF;
      S_IREF: begin
        cmdOut            = CMD_REF;
        strobe.initRefInc = 1'b1;
        strobe.loadWait   = 1'b1;
        strobe.waitKind   = WK_TRC;
        stateNxt          = S_IWAIT;
      end
      S_IWAIT: if (waitDone) stateNxt = initRefDone ? S_MRS : S_IREF;
      S_MRS: begin
        cmdOut          = CMD_MRS;
        strobe.loadWait = 1'b1;
        strobe.waitKind = WK_MRD;
        stateNxt        = S_MWAIT;
      end
      S_MWAIT: if (waitDone) stateNxt = S_IDLE;
      S_IDLE: begin
        readyOut      = 1'b1;
        strobe.tickEn = 1'b1;
        busReqOut     = pendingNz || selfRefReq;
        if (selfRefReq && busGnt) begin
          cmdOut           = CMD_REF;
          ckeOut           = 1'b0;
          strobe.srefEnter = 1'b1;
          stateNxt         = S_SREF;
        end else if (pendingNz && busGnt) begin
          cmdOut          = CMD_REF;
          strobe.refDone  = 1'b1;
          strobe.loadWait = 1'b1;
          strobe.waitKind = WK_TRC;
          stateNxt        = S_RWAIT;
        end
      end
      S_RWAIT: begin
        readyOut      = 1'b1;
        strobe.tickEn = 1'b1;
        busReqOut     = 1'b1;
        if (waitDone) stateNxt = S_IDLE;
      end
      S_SREF: begin
        ckeOut = 1'b0;
        if (!selfRefReq) begin
          strobe.loadWait = 1'b1;
          strobe.waitKind = WK_XSR;
          stateNxt        = S_XWAIT;
        end
      end
      S_XWAIT: if (waitDone) stateNxt = S_IDLE;
      default: stateNxt = S_STAB;
    endcase
  end

  // ---------------- gap tracking for the checks ----------------
  localparam int GAP_MAX = TRC_CYCLES + TRP_CYCLES + MRD_CYCLES + 2;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);

  logic [GAP_W-1:0] sinceCmd;
  logic             lastRef, lastPrea, lastMrs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceCmd <= GAP_W'(GAP_MAX);
      lastRef  <= 1'b0;
      lastPrea <= 1'b0;
      lastMrs  <= 1'b0;
    end else if (cmdOut != CMD_NOP) begin
      sinceCmd <= GAP_W'(1);
      lastRef  <= (cmdOut == CMD_REF);
      lastPrea <= (cmdOut == CMD_PREA);
      lastMrs  <= (cmdOut == CMD_MRS);
    end else if (sinceCmd != GAP_W'(GAP_MAX)) begin
      sinceCmd <= sinceCmd + 1'b1;
    end
  end

  AST_TRC_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut != CMD_NOP && lastRef) |-> sinceCmd >= GAP_W'(TRC_CYCLES));   // R3
  AST_TRP_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut != CMD_NOP && lastPrea) |-> sinceCmd >= GAP_W'(TRP_CYCLES));  // R3
  AST_MRS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut != CMD_NOP && lastMrs) |-> sinceCmd >= GAP_W'(MRD_CYCLES));   // R4
  AST_CKE_LOW_NOP: assert property (@(posedge clk) disable iff (!rstN)
    (!ckeOut && $past(!ckeOut)) |-> cmdOut == CMD_NOP);                    // R8
  AST_EXIT_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ckeOut) |-> !readyOut);                                         // R9

endmodule

// File: rtl/dram_maint_seq.sv
module dram_maint_seq
  import dram_maint_pkg::*;
#(
  parameter int STAB_CYCLES    = 8,
  parameter int PWRUP_CYCLES   = 5000,
  parameter int TRP_CYCLES     = 3,
  parameter int TRC_CYCLES     = 4,
  parameter int MRD_CYCLES     = 2,
  parameter int INIT_REFRESHES = 8,
  parameter int REF_PERIOD_4K  = 780,
  parameter int PEND_MAX       = 4,
  parameter int ADDR_W         = 13,
  parameter int AP_BIT         = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bigRows,
  input  logic              selfRefReq,
  input  logic              busGnt,
  input  logic [ADDR_W-1:0] modeWord,
  output logic [2:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              cke,
  output logic              ready,
  output logic              busReq
);

  ctlStrobe_t strobe;
  cmd_e       cmdE;
  logic       waitDone, initRefDone, pendingNz;

  dram_maint_ctl #(
    .TRP_CYCLES (TRP_CYCLES),
    .TRC_CYCLES (TRC_CYCLES),
    .MRD_CYCLES (MRD_CYCLES)
  ) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .waitDone    (waitDone),
    .initRefDone (initRefDone),
    .pendingNz   (pendingNz),
    .busGnt      (busGnt),
    .selfRefReq  (selfRefReq),
    .strobe      (strobe),
    .cmdOut      (cmdE),
    .ckeOut      (cke),
    .readyOut    (ready),
    .busReqOut   (busReq)
  );

  dram_maint_dp #(
    .STAB_CYCLES    (STAB_CYCLES),
    .PWRUP_CYCLES   (PWRUP_CYCLES),
    .TRP_CYCLES     (TRP_CYCLES),
    .TRC_CYCLES     (TRC_CYCLES),
    .MRD_CYCLES     (MRD_CYCLES),
    .INIT_REFRESHES (INIT_REFRESHES),
    .REF_PERIOD_4K  (REF_PERIOD_4K),
    .PEND_MAX       (PEND_MAX)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .bigRows     (bigRows),
    .waitDone    (waitDone),
    .initRefDone (initRefDone),
    .pendingNz   (pendingNz)
  );

  assign cmd = cmdE;

  always_comb begin
    addr = '0;
    if (cmdE == CMD_MRS)       addr = modeWord;
    else if (cmdE == CMD_PREA) addr[AP_BIT] = 1'b1;
  end

  AST_REF_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rstN)
    (cmdE == CMD_REF && ready) |-> busGnt);                    // R6
  AST_MRS_AFTER_ALL_REF: assert property (@(posedge clk) disable iff (!rstN)
    (cmdE == CMD_MRS) |-> initRefDone);                        // R2

endmodule

// File: tb/tb_dram_maint_seq.sv
module tb_dram_maint_seq;

  localparam int STAB  = 8;
  localparam int PWRUP = 5000;
  localparam int TRP   = 3;
  localparam int TRC   = 4;
  localparam int MRD   = 2;
  localparam int NINIT = 8;
  localparam int P4K   = 780;
  localparam int P8K   = P4K / 2;
  localparam int PMAX  = 4;
  localparam int AW    = 13;
  localparam int APB   = 10;

  // vector: {bigRows, expected refresh spacing}
  localparam logic [16:0] VEC [4] = '{
    {1'b0, 16'(P4K)}, {1'b1, 16'(P8K)}, {1'b1, 16'(P8K)}, {1'b0, 16'(P4K)}
  };

  logic          clk = 1'b0, rstN = 1'b0;
  logic          bigRows = 1'b0, selfRefReq = 1'b0, busGnt = 1'b0;
  logic [AW-1:0] modeWord = 13'h0232;
  logic [2:0]    cmd;
  logic [AW-1:0] addr;
  logic          cke, ready, busReq;

  dram_maint_seq #(
    .STAB_CYCLES(STAB), .PWRUP_CYCLES(PWRUP), .TRP_CYCLES(TRP), .TRC_CYCLES(TRC),
    .MRD_CYCLES(MRD), .INIT_REFRESHES(NINIT), .REF_PERIOD_4K(P4K), .PEND_MAX(PMAX),
    .ADDR_W(AW), .AP_BIT(APB)
  ) dut (
    .clk(clk), .rstN(rstN), .bigRows(bigRows), .selfRefReq(selfRefReq),
    .busGnt(busGnt), .modeWord(modeWord), .cmd(cmd), .addr(addr),
    .cke(cke), .ready(ready), .busReq(busReq)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drivePoint();
    @(posedge clk);
    #2;
  endtask

  task automatic nextRef(input int limit, output int at);
    at = -1;
    for (int n = 0; n < limit; n++) begin
      @(negedge clk);
      if (cmd == 3'd2 && cke) begin
        at = cyc;
        break;
      end
    end
  endtask

  initial begin
    while (cyc < 150000) begin
      @(posedge clk);
      #1;
    end
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog (all requirements): actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int c0, prea, mrs, rdy, nref, nother, t, a, b, cnt, tc, bad;
    int refs[16];
    logic [AW-1:0] addrPrea, addrMrs;
    prea = -1; mrs = -1; rdy = -1; nref = 0; nother = 0;
    addrPrea = '0; addrMrs = '0;
    for (int i = 0; i < 16; i++) refs[i] = 0;

    // ---- reset state (R1)
    repeat (3) @(negedge clk);
    chk(cmd == 3'd0, "R1 reset cmd", int'(cmd), 0);
    chk(cke == 1'b1, "R1 reset cke", int'(cke), 1);
    chk(ready == 1'b0 && busReq == 1'b0, "R1 reset ready/busReq", int'({ready, busReq}), 0);

    drivePoint();
    rstN   = 1'b1;
    busGnt = 1'b1;
    c0     = cyc;

    // ---- start-up sequence monitor
    for (int n = 0; n < PWRUP + 2000 && rdy < 0; n++) begin
      @(negedge clk);
      if (ready) rdy = cyc;
      case (cmd)
        3'd0: ;
        3'd1: if (prea < 0) begin prea = cyc; addrPrea = addr; end else nother++;
        3'd2: begin if (nref < 16) refs[nref] = cyc; nref++; end
        3'd3: begin if (mrs < 0) begin mrs = cyc; addrMrs = addr; end else nother++; end
        default: nother++;
      endcase
    end
    chk(prea - c0 == STAB + PWRUP, "R1 first command cycle", prea - c0, STAB + PWRUP);
    chk(addrPrea[APB] == 1'b1, "R1 precharge-all address bit", int'(addrPrea[APB]), 1);
    chk(nref == NINIT, "R2 start-up refresh count", nref, NINIT);
    chk(nother == 0, "R2 stray commands", nother, 0);
    chk(addrMrs == modeWord, "R2 mode word on addr", int'(addrMrs), int'(modeWord));
    chk(refs[0] - prea == TRP, "R3 precharge to refresh", refs[0] - prea, TRP);
    for (int i = 1; i < NINIT; i++)
      chk(refs[i] - refs[i-1] == TRC, "R3 refresh to refresh", refs[i] - refs[i-1], TRC);
    chk(mrs - refs[NINIT-1] == TRC, "R3 refresh to mode write", mrs - refs[NINIT-1], TRC);
    chk(rdy - mrs == MRD, "R4 mode write to ready", rdy - mrs, MRD);

    // ---- first periodic refresh (R5)
    nextRef(P4K + 20, t);
    chk(t - rdy == P4K, "R5 first periodic refresh", t - rdy, P4K);

    // ---- vector table: spacing per row setting (R5)
    for (int v = 0; v < 4; v++) begin
      drivePoint();
      bigRows = VEC[v][16];
      nextRef(P4K + 20, t);
      nextRef(P4K + 20, a);
      nextRef(P4K + 20, b);
      chk(b - a == int'(VEC[v][15:0]), "R5 refresh spacing", b - a, int'(VEC[v][15:0]));
    end

    // ---- postponement and saturation (R6, R7)
    drivePoint();
    busGnt  = 1'b0;
    bigRows = 1'b1;
    for (int n = 0; n < 20 && busReq; n++) @(negedge clk);
    t = -1;
    for (int n = 0; n < P8K + 20; n++) begin
      @(negedge clk);
      if (busReq) begin t = cyc; break; end
    end
    chk(t >= 0, "R6 busReq raised when owed", t, 1);
    cnt = 0; bad = 0;
    for (int n = 0; n < 3 * P8K; n++) begin
      @(negedge clk);
      if (cmd == 3'd2) cnt++;
      if (!busReq) bad++;
    end
    chk(cnt == 0, "R6 no refresh without grant", cnt, 0);
    chk(bad == 0, "R6 busReq held while owed", bad, 0);
    while (cyc < t + 4 * P8K + P8K / 2) begin
      @(posedge clk);
      #2;
    end
    busGnt = 1'b1;
    cnt = 0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (cmd == 3'd2 && cke) begin
        if (cnt < 16) refs[cnt] = cyc;
        cnt++;
      end
    end
    chk(cnt == PMAX, "R7 saturated refresh count", cnt, PMAX);
    for (int i = 1; i < PMAX && i < cnt; i++)
      chk(refs[i] - refs[i-1] == TRC, "R7 catch-up spacing", refs[i] - refs[i-1], TRC);

    // ---- self-refresh (R8, R9)
    drivePoint();
    busGnt     = 1'b0;
    bigRows    = 1'b0;
    selfRefReq = 1'b1;
    repeat (10) @(negedge clk);
    chk(cke == 1'b1, "R8 no entry without grant", int'(cke), 1);
    chk(busReq == 1'b1, "R8 busReq on self-refresh request", int'(busReq), 1);
    drivePoint();
    busGnt = 1'b1;
    a = -1;
    for (int n = 0; n < 20; n++) begin
      if (n > 0) @(negedge clk); else #8;
      if (!cke) begin a = int'(cmd); break; end
    end
    chk(a == 2, "R8 entry is refresh with cke low", a, 2);
    bad = 0;
    for (int n = 0; n < 30; n++) begin
      @(negedge clk);
      if (cke || cmd != 3'd0 || ready) bad++;
    end
    chk(bad == 0, "R8 quiet while in self-refresh", bad, 0);
    drivePoint();
    selfRefReq = 1'b0;
    @(negedge clk);
    chk(cke == 1'b0, "R9 cke still low in request-drop cycle", int'(cke), 0);
    @(negedge clk);
    chk(cke == 1'b1, "R9 cke rises next cycle", int'(cke), 1);
    tc = cyc; rdy = -1; bad = 0;
    for (int n = 0; n < 50 && rdy < 0; n++) begin
      if (ready) rdy = cyc;
      else begin
        if (cmd != 3'd0) bad++;
        @(negedge clk);
      end
    end
    chk(rdy - tc == TRC + 1, "R9 exit wait", rdy - tc, TRC + 1);
    chk(bad == 0, "R9 no command during exit wait", bad, 0);
    nextRef(P4K + 20, t);
    chk(t - rdy == P4K, "R8 interval restarted after self-refresh", t - rdy, P4K);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule